// File: doc/BRIEF.md
# Rate 2/3 Recursive Convolutional Encoder

This block takes a stream of 2-bit data words and turns each accepted word into one 3-bit channel symbol. The upper data bit is sent without coding. The other two symbol bits come from a 4-state recursive trellis that is held in two state flip-flops. A word is accepted on any clock where the input qualifier is high. Its symbol appears on the registered output one clock later, together with an output qualifier. On clocks where the qualifier is low, the trellis and the symbol output keep their values.

The trellis state is an enumerated type with four states. Write it as the pair (b, a), where a is the state bit that is sent directly as the lowest symbol bit and b is the state bit that is mixed with the lower data bit:

- `ST_ZZ` is (0,0).
- `ST_ZA` is (0,1).
- `ST_BZ` is (1,0).
- `ST_BA` is (1,1).

Each accepted word moves the state along one of eight named transitions, chosen by the lower data bit d0:

| From | d0 = 0 | d0 = 1 |
|---|---|---|
| `ST_ZZ` | `ST_ZZ` (T_ZZ_STAY) | `ST_BZ` (T_ZZ_KICK) |
| `ST_ZA` | `ST_BZ` (T_ZA_SHIFT) | `ST_ZZ` (T_ZA_CLEAR) |
| `ST_BZ` | `ST_ZA` (T_BZ_SHIFT) | `ST_BA` (T_BZ_FILL) |
| `ST_BA` | `ST_BA` (T_BA_STAY) | `ST_ZA` (T_BA_DROP) |

Reset puts the trellis in `ST_ZZ`.

The encoder sits between a framing stage and a symbol mapper, and feeds a matching 4-state soft-decision trellis decoder. Puncturing, termination and tail-biting are left to the stages around it.

Top module: `conv23_enc`

## Requirements
- R1: Each clock with `in_vld` high accepts one word. On the next clock `sym_vld` is high and `sym_out` carries that word's symbol.
- R2: `sym_out[2]` equals bit 1 of the accepted word, with no coding.
- R3: `sym_out[1]` equals bit 0 of the accepted word XOR state bit b, taken from the state before the word.
- R4: `sym_out[0]` equals state bit a, taken from the state before the word.
- R5: On each accepted word the state updates as a_next = b and b_next = a XOR d0. This follows the eight transitions in the table, and every state/input pair can be reached.
- R6: A clock with `in_vld` low leaves the state unchanged, holds `sym_out`, and drives `sym_vld` low on the next clock.
- R7: A synchronous active-high `rst` clears `sym_out` to 0, clears `sym_vld`, and puts the state in `ST_ZZ`. The first symbol after reset is therefore {d1, d0, 0}.
- R8: From reset, a run of words with d0 = 1 cycles through ZZ, BZ, BA, ZA with period 4. The symbol bits [1:0] then repeat the sequence 2'b10, 2'b00, 2'b01, 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input word qualifier |
| in_word | input | 2 | Data word; bit 1 is uncoded, bit 0 drives the trellis |
| sym_out | output | 3 | Registered channel symbol |
| sym_vld | output | 1 | Symbol qualifier, one clock after acceptance |

## Verification
On every cycle the assertions check the following:

- The output qualifier follows the input qualifier with one clock of delay.
- The uncoded bit passes through.
- The symbol is held across idle clocks.
- The state is cleared after reset.
- The recursion a_next = b holds across back-to-back words, checked by rebuilding b from one symbol and its input and comparing it with the next symbol's low bit.

The bench's scenarios are needed for the rest:

- Visiting all sixteen state/input pairs.
- Confirming that the state survives idle gaps unchanged.
- The fixed period-4 pattern from reset.
- The first symbol after a reset in the middle of a stream.

// File: rtl/conv23_pkg.sv
package conv23_pkg;
    localparam int unsigned WORD_W  = 2;
    localparam int unsigned SYM_W   = WORD_W + 1;
    localparam int unsigned STATE_W = 2;

    // encoding {b, a}: a goes to symbol bit 0, b is mixed with d0
    typedef enum logic [STATE_W-1:0] {
        ST_ZZ = 2'b00,
        ST_ZA = 2'b01,
        ST_BZ = 2'b10,
        ST_BA = 2'b11
    } trellis_e;

    typedef enum logic [2:0] {
        T_ZZ_STAY  = 3'd0,
        T_ZZ_KICK  = 3'd1,
        T_ZA_SHIFT = 3'd2,
        T_ZA_CLEAR = 3'd3,
        T_BZ_SHIFT = 3'd4,
        T_BZ_FILL  = 3'd5,
        T_BA_STAY  = 3'd6,
        T_BA_DROP  = 3'd7
    } trans_e;
endpackage

// File: rtl/conv23_trellis.sv
module conv23_trellis
    import conv23_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  logic     d0,
    output trellis_e cur,
    output logic     tap_a,
    output logic     tap_b
);
    trellis_e nxt;
    trans_e   edge_sel;

    // transition choice: one named edge per state/input pair
    always_comb begin
        unique case (cur)
            ST_ZZ:   edge_sel = d0 ? T_ZZ_KICK  : T_ZZ_STAY;
            ST_ZA:   edge_sel = d0 ? T_ZA_CLEAR : T_ZA_SHIFT;
            ST_BZ:   edge_sel = d0 ? T_BZ_FILL  : T_BZ_SHIFT;
            ST_BA:   edge_sel = d0 ? T_BA_DROP  : T_BA_STAY;
            default: edge_sel = T_ZZ_STAY;
        endcase
    end

    always_comb begin
        unique case (edge_sel)
            T_ZZ_STAY:  nxt = ST_ZZ;
            T_ZZ_KICK:  nxt = ST_BZ;
            T_ZA_SHIFT: nxt = ST_BZ;
            T_ZA_CLEAR: nxt = ST_ZZ;
            T_BZ_SHIFT: nxt = ST_ZA;
            T_BZ_FILL:  nxt = ST_BA;
            T_BA_STAY:  nxt = ST_BA;
            T_BA_DROP:  nxt = ST_ZA;
            default:    nxt = ST_ZZ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= ST_ZZ;
        else if (adv)
            cur <= nxt;
    end

    always_comb begin
        unique case (cur)
            ST_ZZ:   begin tap_a = 1'b0; tap_b = 1'b0; end
            ST_ZA:   begin tap_a = 1'b1; tap_b = 1'b0; end
            ST_BZ:   begin tap_a = 1'b0; tap_b = 1'b1; end
            ST_BA:   begin tap_a = 1'b1; tap_b = 1'b1; end
            default: begin tap_a = 1'b0; tap_b = 1'b0; end
        endcase
    end
endmodule

// File: rtl/conv23_branch.sv
module conv23_branch
    import conv23_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              tap_a,
    input  logic              tap_b,
    output logic [SYM_W-1:0]  sym
);
    // pass-through bits above the coded pair
    for (genvar g = 2; g < SYM_W; g++) begin : g_plain
        assign sym[g] = word[g-1];
    end
    assign sym[1] = word[0] ^ tap_b;
    assign sym[0] = tap_a;
endmodule

// File: rtl/conv23_symreg.sv
module conv23_symreg
    import conv23_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SYM_W-1:0] sym_d,
    output logic [SYM_W-1:0] sym_q,
    output logic             vld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= load;
            if (load)
                sym_q <= sym_d;
        end
    end
endmodule

// File: rtl/conv23_enc.sv
module conv23_enc
    import conv23_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    output logic [SYM_W-1:0]  sym_out,
    output logic              sym_vld
);
    trellis_e            state;
    logic                tap_a;
    logic                tap_b;
    logic [SYM_W-1:0]    sym_d;

    conv23_trellis u_trellis (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_vld),
        .d0    (in_word[0]),
        .cur   (state),
        .tap_a (tap_a),
        .tap_b (tap_b)
    );

    conv23_branch u_branch (
        .word  (in_word),
        .tap_a (tap_a),
        .tap_b (tap_b),
        .sym   (sym_d)
    );

    conv23_symreg u_symreg (
        .clk   (clk),
        .rst   (rst),
        .load  (in_vld),
        .sym_d (sym_d),
        .sym_q (sym_out),
        .vld_q (sym_vld)
    );
endmodule

// File: rtl/conv23_enc_chk.sv
module conv23_enc_chk
    import conv23_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [WORD_W-1:0] in_word,
    input logic [SYM_W-1:0]  sym_out,
    input logic              sym_vld
);
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> sym_vld); // R1
    AST_UNCODED_PASS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> sym_out[2] == $past(in_word[1])); // R2
    AST_RECURSION: assert property (@(posedge clk) disable iff (rst)
        (in_vld && $past(in_vld) && !$past(rst))
        |=> sym_out[0] == ($past(sym_out[1]) ^ $past(in_word[0], 2))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(sym_out) && !sym_vld)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sym_out == '0 && !sym_vld)); // R7
endmodule

bind conv23_enc conv23_enc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_word (in_word),
    .sym_out (sym_out),
    .sym_vld (sym_vld)
);

// File: tb/sim_conv23_enc.sv
`timescale 1ns/1ps
module sim_conv23_enc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [1:0] in_word = 2'b00;
    logic [2:0] sym_out;
    logic       sym_vld;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state bits
    logic ma = 1'b0;
    logic mb = 1'b0;
    logic [2:0] last_sym = 3'b000;
    bit   seen [16];

    always #2.5 clk = ~clk;

    conv23_enc u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
        .sym_out(sym_out), .sym_vld(sym_vld)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_vld = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        ma = 1'b0; mb = 1'b0; last_sym = 3'b000;
        chk("R7", {1'b0, sym_out}, 4'h0);
        chk("R7", {3'b0, sym_vld}, 4'h0);
    endtask

    // apply one clock of stimulus and check the registered result
    task automatic step(input logic v, input logic [1:0] w);
        logic [2:0] e;
        in_vld = v; in_word = w;
        e = {w[1], w[0] ^ mb, ma};
        @(posedge clk); #1;
        if (v) begin
            seen[{mb, ma, w}] = 1'b1;
            chk("R1", {3'b0, sym_vld}, 4'h1);
            chk("R2", {3'b0, sym_out[2]}, {3'b0, e[2]});
            chk("R3", {3'b0, sym_out[1]}, {3'b0, e[1]});
            chk("R4", {3'b0, sym_out[0]}, {3'b0, e[0]});
            {mb, ma} = {ma ^ w[0], mb};
            last_sym = e;
        end else begin
            chk("R6", {3'b0, sym_vld}, 4'h0);
            chk("R6", {1'b0, sym_out}, {1'b0, last_sym});
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [1:0] pat [4];
        pat[0] = 2'b10; pat[1] = 2'b00; pat[2] = 2'b01; pat[3] = 2'b11;
        do_reset();

        // R7: first symbol comes from the cleared state
        step(1'b1, 2'b11);
        chk("R7", {1'b0, sym_out}, 4'b0110);

        // R8: d0 held at 1 from reset, fixed period-4 pattern
        do_reset();
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 2'b01);
            chk("R8", {2'b0, sym_out[1:0]}, {2'b0, pat[i % 4]});
        end

        // R6: idle gap must keep the state; resume and compare to model
        step(1'b0, 2'b10);
        step(1'b0, 2'b11);
        step(1'b1, 2'b00);

        // R5: pseudo-random sweep with gaps, all pairs must be visited
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:2] != 2'b00, lfsr[1:0]);
            if (i == 1500) do_reset();
        end
        for (int k = 0; k < 16; k++)
            chk("R5", {3'b0, seen[k]}, 4'h1);

        // R7: reset in the middle of a stream, then the first symbol again
        step(1'b1, 2'b01);
        do_reset();
        step(1'b1, 2'b01);
        chk("R7", {1'b0, sym_out}, 4'b0010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule